// File: doc/BRIEF.md
# Periodic Software Timer

This block is a free-running interval timer that software arms by writing a 16-bit period. The system clock is divided by a prescaler down to a base tick of 10.24 µs. The period counts those ticks, so a value of 48,828 gives an interval of roughly half a second. Until the first write after hard reset, the timer stays quiet. From the first write onward it runs without stopping, and it sets a sticky interrupt flag at the end of every interval. Software reads the flag and acknowledges it through a clear input.

The period sits in the low half of a 32-bit register. The upper half is reserved: it is dropped on write and reads as zero. Hard reset loads the period with FFFFh and returns the timer to the unarmed state. A period of zero is not a meaningful setting. The block runs it exactly like a period of one so that behaviour stays deterministic. Writing a new period while the timer runs discards the interval in progress and restarts timing from the write.

Top module: `periodic_sw_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, `rd_data` reads 32'h0000FFFF and `irq_flag` is 0.
- R2: After reset and before any write, `irq_flag` stays 0 no matter how long the timer is left alone.
- R3: A write stores `wr_data[15:0]` as the period. From the cycle after the write, `rd_data[15:0]` returns it and `rd_data[31:16]` reads 0, whatever was written to bits 31:16.
- R4: A write with period P ≥ 1 lands on clock edge E. The flag first rises on edge E + P·TICK_DIV.
- R5: After the first expiry the timer keeps running. It raises the flag again every P·TICK_DIV clocks, and it raises the flag at no other time.
- R6: Once set, `irq_flag` stays 1 until `irq_clr` is sampled high. It then reads 0 from the next cycle, unless a new expiry falls on that same edge.
- R7: If `irq_clr` and an expiry occur on the same edge, `irq_flag` remains 1.
- R8: A written period of 0 reads back as 0 and times exactly like a period of 1, which is one expiry every TICK_DIV clocks.
- R9: A write while the timer runs discards the partial interval, including the prescaler phase. The next expiry follows the R4 timing measured from the new write.
- R10: Hard reset at any time clears the flag, reloads FFFFh and returns the timer to the unarmed state of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard reset, asynchronous assert |
| wr_en | input | 1 | Period register write strobe |
| wr_data | input | 32 | Write data; bits 15:0 are the period, bits 31:16 are ignored |
| rd_data | output | 32 | Period register read value; upper half reads zero |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky expiry flag |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on the same edge as a fresh expiry. The bench has to know the exact expiry edge before it can aim the clear at it. To get there, the bench turns off its automatic acknowledge and lets one expiry set the flag. It then counts clocks from the write to the next expiry and raises `irq_clr` on the edge just before it, so the clear and the expiry share one edge. A mid-interval rewrite is also checked. A design that kept the old prescaler phase or the old count would shift every later expiry that the scoreboard predicts.

// File: rtl/swt_pkg.sv
`timescale 1ns/1ps
package swt_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned PERIOD_W = 16;
    localparam logic [PERIOD_W-1:0] PERIOD_RST = 16'hFFFF;

    typedef struct packed {
        logic                started;
        logic [PERIOD_W-1:0] period;
    } period_reg_t;

    typedef struct packed {
        logic [PERIOD_W-1:0] count;
    } interval_t;

    typedef struct packed {
        logic flag;
    } flag_t;

    // A zero period is run as one tick per interval.
    function automatic logic [PERIOD_W-1:0] eff_period(input logic [PERIOD_W-1:0] p);
        return (p == '0) ? {{(PERIOD_W-1){1'b0}}, 1'b1} : p;
    endfunction

endpackage

// File: rtl/swt_prescaler.sv
`timescale 1ns/1ps
module swt_prescaler #(
    parameter int unsigned TICK_DIV = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic at_last;

    always_comb begin
        pre_d   = pre_q;
        at_last = (pre_q.cnt == LAST);
        if (!run || restart) begin
            pre_d.cnt = '0;
        end else if (at_last) begin
            pre_d.cnt = '0;
        end else begin
            pre_d.cnt = pre_q.cnt + 1'b1;
        end
    end

    assign tick = run & ~restart & at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

endmodule

// File: rtl/swt_period_reg.sv
`timescale 1ns/1ps
module swt_period_reg
    import swt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PERIOD_W-1:0] wr_period,
    output logic [PERIOD_W-1:0] period,
    output logic                started
);
    period_reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            reg_d.period  = wr_period;
            reg_d.started = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.started <= 1'b0;
            reg_q.period  <= PERIOD_RST;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign period  = reg_q.period;
    assign started = reg_q.started;

endmodule

// File: rtl/swt_interval_counter.sv
`timescale 1ns/1ps
module swt_interval_counter
    import swt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                restart,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                expire
);
    interval_t cnt_d, cnt_q;
    logic [PERIOD_W-1:0] last_count;

    always_comb begin
        cnt_d      = cnt_q;
        expire     = 1'b0;
        last_count = eff_period(period) - 1'b1;
        if (!run || restart) begin
            cnt_d.count = '0;
        end else if (tick) begin
            if (cnt_q.count == last_count) begin
                cnt_d.count = '0;
                expire      = 1'b1;
            end else begin
                cnt_d.count = cnt_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/periodic_sw_timer.sv
`timescale 1ns/1ps
module periodic_sw_timer
    import swt_pkg::*;
#(
    parameter int unsigned CLK_KHZ  = 200000,
    parameter int unsigned TICK_DIV = (CLK_KHZ * 1024) / 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             irq_clr,
    output logic             irq_flag
);
    logic [PERIOD_W-1:0] period;
    logic                started;
    logic                tick;
    logic                expire;
    logic                unused_hi;
    flag_t               flg_d, flg_q;

    // Reserved upper half of the register is dropped on write.
    assign unused_hi = ^wr_data[REG_W-1:PERIOD_W];

    swt_period_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_period (wr_data[PERIOD_W-1:0]),
        .period    (period),
        .started   (started)
    );

    swt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (started),
        .restart (wr_en),
        .tick    (tick)
    );

    swt_interval_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (started),
        .restart (wr_en),
        .tick    (tick),
        .period  (period),
        .expire  (expire)
    );

    // An expiry wins over a clear on the same edge.
    always_comb begin
        flg_d      = flg_q;
        flg_d.flag = expire | (flg_q.flag & ~irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign irq_flag = flg_q.flag;
    assign rd_data  = {{(REG_W-PERIOD_W){1'b0}}, period};

endmodule

// File: rtl/swt_checker.sv
`timescale 1ns/1ps
module swt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] wr_lo,
    input logic [31:0] rd_data,
    input logic        irq_clr,
    input logic        irq_flag
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= 1'b1;
        end
    end

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data == 32'h0000FFFF) && !irq_flag);

    assert_idle_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !irq_flag);

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31:16] == 16'h0000);

    assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[15:0] == $past(wr_lo));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);

endmodule

bind periodic_sw_timer swt_checker u_swt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_lo    (wr_data[15:0]),
    .rd_data  (rd_data),
    .irq_clr  (irq_clr),
    .irq_flag (irq_flag)
);

// File: tb/periodic_sw_timer_tb_top.sv
`timescale 1ns/1ps
module periodic_sw_timer_tb_top;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_clr;
    logic        irq_flag;
    logic        mon_clr = 1'b0;
    logic        man_clr = 1'b0;
    logic        prev_flag = 1'b0;
    bit          auto_clr = 1'b1;
    bit          done = 1'b0;
    int          cyc = 0;
    int          errors = 0;
    int          checks = 0;
    int          exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign irq_clr = mon_clr | man_clr;

    periodic_sw_timer #(.TICK_DIV(DIV)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_clr  (irq_clr),
        .irq_flag (irq_flag)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: pops predicted rise cycles and compares them with observed rises.
    always @(negedge clk) begin
        int e;
        if (!rst_n) begin
            prev_flag = 1'b0;
            mon_clr   = 1'b0;
        end else begin
            mon_clr = 1'b0;
            if (irq_flag && !prev_flag) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R5: actual=unexpected rise at %0d expected=no rise", cyc);
                end else begin
                    e = exp_q.pop_front();
                    if (e != cyc) begin
                        errors++;
                        $display("FAIL R4/R5: actual=rise at %0d expected=rise at %0d", cyc, e);
                    end
                end
                if (auto_clr) mon_clr = 1'b1;
            end
            prev_flag = irq_flag;
        end
    end

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Driver: writes a period and pushes the n expiry cycles it must produce.
    task automatic start_period(input logic [31:0] val, input int n, output int last);
        int c;
        int eff;
        @(negedge clk);
        c   = cyc;
        eff = (val[15:0] == 16'h0) ? 1 : int'(val[15:0]);
        for (int k = 1; k <= n; k++) exp_q.push_back(c + 1 + k * eff * DIV);
        wr_en   = 1'b1;
        wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
        chk(rd_data == {16'h0, val[15:0]}, "R3", rd_data, {16'h0, val[15:0]});
        last = c + 1 + n * eff * DIV;
        if (n > 0) begin
            wait_until(last + 1);
            chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        end
    endtask

    initial begin
        int last;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(rd_data == 32'h0000FFFF, "R1", rd_data, 32'h0000FFFF);
        chk(irq_flag == 1'b0, "R1", irq_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 32'h0000FFFF, "R1", rd_data, 32'h0000FFFF);
        // R2: unarmed timer stays silent
        repeat (300) @(negedge clk);
        chk(irq_flag == 1'b0, "R2", irq_flag, 0);

        // R3 R4 R5: reserved bits dropped, period 3
        start_period(32'hABCD_0003, 4, last);

        // R9: rewrite mid-interval restarts timing
        start_period(32'h0000_0005, 0, last);
        repeat (7) @(negedge clk);
        chk(irq_flag == 1'b0, "R9", irq_flag, 0);
        start_period(32'h0000_0002, 3, last);

        // R8: zero period behaves as one
        start_period(32'h0000_0000, 4, last);

        // R6 R7: sticky flag and clear colliding with expiry
        auto_clr = 1'b0;
        start_period(32'h0000_0002, 1, last);
        wait_until(last + 4);
        chk(irq_flag == 1'b1, "R6", irq_flag, 1);
        wait_until(last + 7);
        man_clr = 1'b1;
        @(negedge clk);
        man_clr = 1'b0;
        chk(irq_flag == 1'b1, "R7", irq_flag, 1);
        man_clr = 1'b1;
        @(negedge clk);
        man_clr = 1'b0;
        chk(irq_flag == 1'b0, "R6", irq_flag, 0);

        // R10: hard reset while running
        rst_n = 1'b0;
        @(negedge clk);
        chk(rd_data == 32'h0000FFFF, "R10", rd_data, 32'h0000FFFF);
        chk(irq_flag == 1'b0, "R10", irq_flag, 0);
        auto_clr = 1'b1;
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk(irq_flag == 1'b0, "R10", irq_flag, 0);
        chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
        start_period(32'h0000_0001, 3, last);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule